// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a small stored-program processor built around a single 16-bit accumulator and a 14-bit program counter. It reads instructions and operands from a synchronous single-port memory and writes results back to it. The memory is 16 bits wide and has 14-bit addresses. The address, the outgoing data and the fetched instruction sit in internal registers that a program cannot reach. A multi-cycle control sequence fetches each instruction word, decodes it, and then reads memory, writes memory or updates the program counter.

The instruction set has four operations: load, store, add, and a branch taken when the accumulator is negative. A halt input can hold the processor between instructions. The host brings the processor out of reset with a program already placed in memory. The program's effect shows up as writes on the memory port.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word carries the opcode in bits 15:14 and a 14-bit address in bits 13:0. That address is the one driven on `mem_addr_o` when the instruction reads or writes data.
- R2: Opcode 00 replaces the accumulator with the memory word at the operand address.
- R3: Opcode 01 raises `mem_we_o` for exactly one cycle, with `mem_addr_o` equal to the operand and `mem_wdata_o` equal to the accumulator. A store leaves the accumulator unchanged.
- R4: Opcode 10 adds the memory word at the operand address to the accumulator. The sum wraps modulo 2^16 and the carry is dropped.
- R5: Opcode 11 loads the operand into the program counter when accumulator bit 15 is 1. When that bit is 0, execution continues with the next word.
- R6: The program counter advances by one on every instruction fetch and wraps from 0x3FFF to 0x0000. A taken branch replaces the advanced value.
- R7: While `rst_n` is low, `mem_we_o` is 0 and `mem_addr_o` is 0. After release, the accumulator is 0 and the first instruction comes from address 0.
- R8: A load and an add each take 6 cycles. A store takes 4 cycles and a branch takes 3. The fetch address is on `mem_addr_o` in the second and third cycles. A load or add puts its operand address out in the fourth and fifth cycles. A store writes in its fourth cycle.
- R9: While `halt_i` is high at an instruction boundary, no instruction starts and no memory write occurs. When `halt_i` falls, execution resumes where it stopped.
- R10: Memory read data is used one clock after the address is presented. The control sequence spends a wait cycle before it captures read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | Hold the processor at the next instruction boundary |
| mem_addr_o | output | 14 | Memory address, from the internal address register |
| mem_wdata_o | output | 16 | Memory write data, from the internal data register |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the address |
| mem_we_o | output | 1 | Memory write enable |

## Verification
The bench builds the processor with its default widths: a 16-bit word and a 14-bit address. It attaches a 1024-word memory that aliases the upper address bits. A branch to 0x3FFF therefore lands on a real word, and the fetch that follows shows the program counter wrapping to zero. A behavioural model runs each instruction for its cycle count and predicts the fetch address, the operand address and every write. The bench compares these against the memory port on every clock. The test program covers several cases: an add that carries into the sign bit, an add that overflows past 16 bits, a branch that is taken, a branch that is not taken, and a halt held across several instruction boundaries.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 16,
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o
);
  localparam int OPW = DW - AW;
  localparam logic [OPW-1:0] OP_LD  = OPW'(0);
  localparam logic [OPW-1:0] OP_ST  = OPW'(1);
  localparam logic [OPW-1:0] OP_ADD = OPW'(2);

  typedef enum logic [2:0] {
    S_FETCH, S_WAIT_I, S_DEC, S_WAIT_D, S_READ_D, S_EXEC, S_WRITE
  } state_t;

  state_t        state;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] acc, mbr, ir;

  wire [OPW-1:0] dec_op = mem_rdata_i[DW-1:AW];
  wire [OPW-1:0] ir_op  = ir[DW-1:AW];

  assign mem_addr_o  = mar;
  assign mem_wdata_o = mbr;
  assign mem_we_o    = (state == S_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      acc   <= '0;
      mar   <= '0;
      mbr   <= '0;
      ir    <= '0;
    end else begin
      case (state)
        S_FETCH: if (!halt_i) begin
          mar   <= pc;
          pc    <= pc + AW'(1);
          state <= S_WAIT_I;
        end
        S_WAIT_I: state <= S_DEC;
        S_DEC: begin
          ir  <= mem_rdata_i;
          mar <= mem_rdata_i[AW-1:0];
          if (dec_op == OP_LD || dec_op == OP_ADD) begin
            state <= S_WAIT_D;
          end else if (dec_op == OP_ST) begin
            mbr   <= acc;
            state <= S_WRITE;
          end else begin
            if (acc[DW-1]) pc <= mem_rdata_i[AW-1:0];
            state <= S_FETCH;
          end
        end
        S_WAIT_D: state <= S_READ_D;
        S_READ_D: begin
          mbr   <= mem_rdata_i;
          state <= S_EXEC;
        end
        S_EXEC: begin
          acc   <= (ir_op == OP_ADD) ? acc + mbr : mbr;
          state <= S_FETCH;
        end
        S_WRITE: state <= S_FETCH;
        default: state <= S_FETCH;
      endcase
    end
  end

  p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

  p_wdata_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_wdata_o == acc));

  p_store_keeps_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> $stable(acc));

  p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && !halt_i) |=> (pc == $past(pc) + AW'(1)));

  p_branch_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC && dec_op == 2'b11 && acc[DW-1]) |=> (pc == $past(mem_rdata_i[AW-1:0])));

  p_branch_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC && dec_op == 2'b11 && !acc[DW-1]) |=> $stable(pc));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && halt_i) |=> (state == S_FETCH && $stable(pc) && !mem_we_o));

  p_add_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && ir_op == OP_ADD) |=> (acc == DW'($past(acc) + $past(mbr))));
endmodule

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0;
  logic [13:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_we;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_cpu i_acc_cpu (
    .clk(clk), .rst_n(rst_n), .halt_i(halt),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we)
  );

  logic [15:0] mem [0:1023];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  // behavioural model: instruction-level state plus a cycle index within the instruction
  int          m_pos = 0;
  int          m_len = 0;
  logic [1:0]  m_op = '0;
  logic [13:0] m_opr = '0;
  logic [13:0] m_pc = '0;
  logic [13:0] m_fetch = '0;
  logic [15:0] m_acc = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_pc = '0; m_acc = '0;
    end else if (m_pos == 0) begin
      if (!halt) begin
        m_fetch = m_pc;
        m_op    = mem[m_pc[9:0]][15:14];
        m_opr   = mem[m_pc[9:0]][13:0];
        m_pc    = m_pc + 14'd1;
        m_len   = (m_op == 2'b01) ? 4 : (m_op == 2'b11) ? 3 : 6;
        m_pos   = 1;
      end
    end else if (m_pos == m_len - 1) begin
      case (m_op)
        2'b00: m_acc = mem[m_opr[9:0]];
        2'b10: m_acc = m_acc + mem[m_opr[9:0]];
        2'b11: if (m_acc[15]) m_pc = m_opr;
        default: ;
      endcase
      m_pos = 0;
    end else begin
      m_pos = m_pos + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check(!mem_we && mem_addr == 14'd0, "R7 reset outputs", {mem_we, mem_addr}, 0);
    end else if (!done) begin
      bit exp_we;
      exp_we = (m_pos == 3 && m_op == 2'b01);
      check(mem_we == exp_we, "R8 R9 write timing", mem_we, exp_we);
      if (m_pos == 1 || m_pos == 2)
        check(mem_addr == m_fetch, "R6 R7 fetch address", mem_addr, m_fetch);
      if ((m_pos == 3 || m_pos == 4) && (m_op == 2'b00 || m_op == 2'b10))
        check(mem_addr == m_opr, "R1 R10 operand address", mem_addr, m_opr);
      if (exp_we) begin
        check(mem_addr == m_opr, "R3 store address", mem_addr, m_opr);
        check(mem_wdata == m_acc, "R2 R3 R4 store data", mem_wdata, m_acc);
      end
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[10'h000] = 16'h0100; // load 0x100
    mem[10'h001] = 16'h8101; // add 0x101 -> sign set
    mem[10'h002] = 16'h4180; // store 0x180
    mem[10'h003] = 16'hC010; // branch taken
    mem[10'h004] = 16'h4181; // skipped store
    mem[10'h010] = 16'h8102; // add with carry out
    mem[10'h011] = 16'h4182; // store 0x182
    mem[10'h012] = 16'hC020; // branch not taken
    mem[10'h013] = 16'h0103; // load 0xFFFF
    mem[10'h014] = 16'hFFFF; // branch to 0x3FFF
    mem[10'h3FF] = 16'h4183; // store, then PC wraps to 0
    mem[10'h100] = 16'h7FFF;
    mem[10'h101] = 16'h0001;
    mem[10'h102] = 16'h9000;
    mem[10'h103] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    halt = 1'b1;
    repeat (30) @(negedge clk);
    halt = 1'b0;
    repeat (200) @(negedge clk);
    halt = 1'b1;
    repeat (20) @(negedge clk);
    done = 1'b1;
    check(mem[10'h180] == 16'h8000, "R4 sign-carrying add", mem[10'h180], 16'h8000);
    check(mem[10'h181] == 16'h0000, "R5 skipped store", mem[10'h181], 16'h0000);
    check(mem[10'h182] == 16'h1000, "R4 wrapped add", mem[10'h182], 16'h1000);
    check(mem[10'h183] == 16'hFFFF, "R2 R6 load and PC wrap", mem[10'h183], 16'hFFFF);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("[TB] FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule